// File: doc/BRIEF.md
# Peak-Split Spike Area Feature Extractor

This block turns one detected spike window into a two-number feature for spike sorting. Signed samples arrive one per accepted transfer. The first sample carries a start marker, which typically comes from the strobe of an upstream energy-operator detector. The final sample carries an end marker. The block finds the sample with the largest magnitude (the peak). It reports the summed magnitude of all samples up to and including the peak as the pre-peak area. The summed magnitude of the samples after the peak is the post-peak area.

No samples are stored. The window is cut into equal segments. Each segment keeps a running magnitude total, its own largest magnitude so far, and the running total captured when that largest value appeared. After the last sample, a one-cycle merge picks the segment with the largest local peak. It adds the totals of the earlier segments to that segment's captured sum, and subtracts the result from the grand total to give the post-peak area. The window length and the segment count are parameters, and the length must be a multiple of the count.

Top module: `spk_peak_split_area`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle. After that edge, `out_valid` is 0, `in_ready` is 1, and `out_peak`, `out_pre_area` and `out_post_area` are 0.
- R2: A window opens only on an accepted sample that has `in_start` high while the block is idle. Accepted samples that arrive while idle with `in_start` low are discarded: they produce no result and leave no trace in the next result.
- R3: A sample's magnitude is the absolute value of its two's-complement value, so the most negative code counts as 2^(SAMPLE_W-1). `out_pre_area + out_post_area` equals the sum of the magnitudes of all WIN_LEN samples in the window.
- R4: `out_pre_area` is the sum of the magnitudes from the first sample through the peak sample, both included. `out_post_area` is the sum over the samples after the peak. A window whose samples are all zero gives 0 and 0.
- R5: The peak is the sample with the largest magnitude, and `out_peak` reports that magnitude. Among equal magnitudes, the earliest sample is the peak, whether the equal samples are in the same segment or in different ones.
- R6: `out_valid` is high for exactly one cycle. That cycle is the second cycle after the cycle in which the final sample is accepted. The three result outputs keep their values until the next result.
- R7: `in_ready` is low for exactly the one cycle after the final sample is accepted. It is high in every other cycle.
- R8: The result is correct when the peak falls on the first or the last sample of any segment.
- R9: The window closes after exactly WIN_LEN accepted samples, and `in_last` marks the last of them. An `in_start` raised on a later sample of an open window is treated as ordinary data.
- R10: The accumulators cannot overflow. A window made entirely of the most negative code gives a total of WIN_LEN * 2^(SAMPLE_W-1).
- R11: Cycles with `in_valid` low, inside a window or between windows, do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample present on `in_sample` |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_start | input | 1 | Marks the first sample of a window (detector strobe) |
| in_last | input | 1 | Marks the final sample of a window |
| in_sample | input | SAMPLE_W | Signed two's-complement sample |
| out_valid | output | 1 | One-cycle strobe: a new feature pair is on the outputs |
| out_peak | output | SAMPLE_W | Magnitude of the peak sample |
| out_pre_area | output | SAMPLE_W+clog2(WIN_LEN)+1 | Magnitude sum from the window start through the peak |
| out_post_area | output | SAMPLE_W+clog2(WIN_LEN)+1 | Magnitude sum after the peak |

## Verification
The assertions assume the upstream source behaves in two ways. First, `in_last` is raised only on the WIN_LEN-th accepted sample of an open window, never on a discarded idle sample. Second, that sample is the one on which the internal counters close the window. The stimulus follows both rules. Every window it sends holds exactly WIN_LEN samples, with the end marker on the last one. Idle filler samples keep both markers low. The random stimulus inserts idle cycles between samples, raises a stray start marker inside one window, and draws some windows from a narrow value range so that equal magnitudes occur often.

// File: rtl/spk_pkg.sv
// Package: shared types and width helpers for the peak-split area extractor.
// Assumes: nothing beyond IEEE 1800-2017.
package spk_pkg;

    // Window controller phases.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_MERGE = 2'd2
    } spk_state_e;

    // Accumulator width wide enough for WIN_LEN magnitudes of SAMPLE_W bits.
    function automatic int spk_acc_w(input int sample_w, input int win_len);
        return sample_w + $clog2(win_len) + 1;
    endfunction

endpackage

// File: rtl/spk_win_ctrl.sv
// Module: window controller. It opens a window on a started sample while
// idle, counts segment and position, routes each accepted sample to one
// segment, and spends one cycle in the merge phase after the final sample.
// Assumes: WIN_LEN is a multiple of NUM_SEG; in_last marks the final sample.
module spk_win_ctrl
    import spk_pkg::*;
#(
    parameter int WIN_LEN = 32,
    parameter int NUM_SEG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_start,
    input  logic               in_last,
    output logic               in_ready,
    output logic               seg_clear,
    output logic [NUM_SEG-1:0] seg_en,
    output logic               merge_go
);

    localparam int SEG_LEN = WIN_LEN / NUM_SEG;
    localparam int SEG_IW  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;
    localparam int POS_W   = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;

    spk_state_e        state;
    logic [SEG_IW-1:0] seg_q;
    logic [POS_W-1:0]  pos_q;
    logic [SEG_IW-1:0] cur_seg;
    logic [POS_W-1:0]  cur_pos;
    logic              accept;
    logic              win_begin;
    logic              take;
    logic              final_smp;

    // Handshake and per-sample decode for the current cycle.
    always_comb begin
        in_ready  = (state != ST_MERGE);
        accept    = in_valid && in_ready;
        win_begin = (state == ST_IDLE) && accept && in_start;
        take      = win_begin || ((state == ST_RUN) && accept);
        cur_seg   = win_begin ? '0 : seg_q;
        cur_pos   = win_begin ? '0 : pos_q;
        final_smp = take && (cur_seg == SEG_IW'(NUM_SEG - 1))
                         && (cur_pos == POS_W'(SEG_LEN - 1));
        seg_clear = win_begin;
        merge_go  = (state == ST_MERGE);
    end

    // One enable per segment, selected by the segment counter.
    for (genvar k = 0; k < NUM_SEG; k++) begin : g_en
        assign seg_en[k] = take && (cur_seg == SEG_IW'(k));
    end

    // Phase and position counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            seg_q <= '0;
            pos_q <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_RUN: begin
                    if (take) begin
                        if (final_smp) begin
                            state <= ST_MERGE;
                            seg_q <= '0;
                            pos_q <= '0;
                        end else begin
                            state <= ST_RUN;
                            if (cur_pos == POS_W'(SEG_LEN - 1)) begin
                                pos_q <= '0;
                                seg_q <= cur_seg + 1'b1;
                            end else begin
                                pos_q <= cur_pos + 1'b1;
                                seg_q <= cur_seg;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_ONEHOT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seg_en)); // R8
    AST_LAST_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (in_last == final_smp)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) && !(accept && in_start) |=> (state == ST_IDLE)); // R2

endmodule

// File: rtl/spk_seg_acc.sv
// Module: one segment's local accumulator. It keeps a running magnitude
// total, the largest magnitude seen so far (strictly larger wins, so the
// earliest sample keeps a tie), and the running total captured at that sample.
// Assumes: clear coincides with the first sample of the window.
module spk_seg_acc #(
    parameter int MAG_W = 12,
    parameter int ACC_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic [MAG_W-1:0] mag,
    output logic [MAG_W-1:0] peak,
    output logic [ACC_W-1:0] pre_sum,
    output logic [ACC_W-1:0] total
);

    logic [MAG_W-1:0] base_peak;
    logic [ACC_W-1:0] base_tot;
    logic [ACC_W-1:0] tot_next;
    logic             is_new;

    // Start from zero on a window clear, else from the held values.
    always_comb begin
        base_peak = clear ? '0 : peak;
        base_tot  = clear ? '0 : total;
        tot_next  = base_tot + ACC_W'(mag);
        is_new    = (mag > base_peak);
    end

    // Update the running total; capture the sum when a new maximum appears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak    <= '0;
            pre_sum <= '0;
            total   <= '0;
        end else if (en) begin
            total <= tot_next;
            if (is_new) begin
                peak    <= mag;
                pre_sum <= tot_next;
            end else if (clear) begin
                peak    <= '0;
                pre_sum <= '0;
            end
        end else if (clear) begin
            peak    <= '0;
            pre_sum <= '0;
            total   <= '0;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        en && !clear |=> total >= $past(total)); // R10
    AST_PRE_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
        pre_sum <= total); // R4
    AST_PEAK_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        en && !clear |=> peak >= $past(peak)); // R5

endmodule

// File: rtl/spk_merge.sv
// Module: combinational merge of the segment results. It picks the first
// segment holding the largest local peak, adds the totals of the earlier
// segments to that segment's captured sum, and subtracts from the grand total.
// Assumes: segment results are stable during the merge cycle.
module spk_merge #(
    parameter int NUM_SEG = 4,
    parameter int MAG_W   = 12,
    parameter int ACC_W   = 18
) (
    input  logic [NUM_SEG-1:0][MAG_W-1:0] seg_peak,
    input  logic [NUM_SEG-1:0][ACC_W-1:0] seg_pre,
    input  logic [NUM_SEG-1:0][ACC_W-1:0] seg_tot,
    output logic [MAG_W-1:0]              best_peak,
    output logic [ACC_W-1:0]              glob_pre,
    output logic [ACC_W-1:0]              glob_post
);

    logic [ACC_W-1:0] prefix;
    logic [ACC_W-1:0] bpre;
    logic [MAG_W-1:0] bpk;

    // Walk the segments in order; strict compare keeps the earliest tie.
    always_comb begin
        prefix = '0;
        bpre   = '0;
        bpk    = '0;
        for (int k = 0; k < NUM_SEG; k++) begin
            if (seg_peak[k] > bpk) begin
                bpk  = seg_peak[k];
                bpre = prefix + seg_pre[k];
            end
            prefix = prefix + seg_tot[k];
        end
        best_peak = bpk;
        glob_pre  = bpre;
        glob_post = prefix - bpre;
    end

endmodule

// File: rtl/spk_peak_split_area.sv
// Module: top of the peak-split spike area extractor. It converts each
// sample to its magnitude, feeds the segment accumulators, merges them in
// the cycle after the final sample and registers the feature pair.
// Assumes: WIN_LEN is a multiple of NUM_SEG and WIN_LEN >= 2.
module spk_peak_split_area
    import spk_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int WIN_LEN  = 32,
    parameter int NUM_SEG  = 4,
    localparam int ACC_W   = spk_acc_w(SAMPLE_W, WIN_LEN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic                in_start,
    input  logic                in_last,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_peak,
    output logic [ACC_W-1:0]    out_pre_area,
    output logic [ACC_W-1:0]    out_post_area
);

    logic                              seg_clear;
    logic [NUM_SEG-1:0]                seg_en;
    logic                              merge_go;
    logic [SAMPLE_W-1:0]               mag;
    logic [NUM_SEG-1:0][SAMPLE_W-1:0]  seg_peak;
    logic [NUM_SEG-1:0][ACC_W-1:0]     seg_pre;
    logic [NUM_SEG-1:0][ACC_W-1:0]     seg_tot;
    logic [SAMPLE_W-1:0]               m_peak;
    logic [ACC_W-1:0]                  m_pre;
    logic [ACC_W-1:0]                  m_post;

    // Absolute value; the most negative code maps to 2^(SAMPLE_W-1).
    always_comb begin
        mag = in_sample[SAMPLE_W-1] ? (~in_sample + 1'b1) : in_sample;
    end

    spk_win_ctrl #(
        .WIN_LEN (WIN_LEN),
        .NUM_SEG (NUM_SEG)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_start  (in_start),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .seg_clear (seg_clear),
        .seg_en    (seg_en),
        .merge_go  (merge_go)
    );

    for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
        spk_seg_acc #(
            .MAG_W (SAMPLE_W),
            .ACC_W (ACC_W)
        ) i_seg (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (seg_clear),
            .en      (seg_en[k]),
            .mag     (mag),
            .peak    (seg_peak[k]),
            .pre_sum (seg_pre[k]),
            .total   (seg_tot[k])
        );
    end

    spk_merge #(
        .NUM_SEG (NUM_SEG),
        .MAG_W   (SAMPLE_W),
        .ACC_W   (ACC_W)
    ) i_merge (
        .seg_peak  (seg_peak),
        .seg_pre   (seg_pre),
        .seg_tot   (seg_tot),
        .best_peak (m_peak),
        .glob_pre  (m_pre),
        .glob_post (m_post)
    );

    // Result register: loads in the merge cycle, strobe lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_peak      <= '0;
            out_pre_area  <= '0;
            out_post_area <= '0;
        end else begin
            out_valid <= merge_go;
            if (merge_go) begin
                out_peak      <= m_peak;
                out_pre_area  <= m_pre;
                out_post_area <= m_post;
            end
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_last |=> ##1 out_valid); // R6
    AST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R6
    AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready); // R7

endmodule

// File: tb/test_spk_peak_split_area.sv
module test_spk_peak_split_area;

    localparam int SW         = 12;
    localparam int WIN        = 32;
    localparam int NSEG       = 4;
    localparam int ACC_W      = SW + $clog2(WIN) + 1;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid, in_ready, in_start, in_last;
    logic [SW-1:0]    in_sample;
    logic             out_valid;
    logic [SW-1:0]    out_peak;
    logic [ACC_W-1:0] out_pre_area, out_post_area;

    int total = 0;
    int bad   = 0;
    logic signed [SW-1:0] win [WIN];

    always #(CLK_PERIOD / 2) clk = ~clk;

    spk_peak_split_area #(
        .SAMPLE_W (SW),
        .WIN_LEN  (WIN),
        .NUM_SEG  (NSEG)
    ) i_spk_peak_split_area (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_start      (in_start),
        .in_last       (in_last),
        .in_sample     (in_sample),
        .out_valid     (out_valid),
        .out_peak      (out_peak),
        .out_pre_area  (out_pre_area),
        .out_post_area (out_post_area)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference: magnitude peak (earliest on tie), split sums.
    function automatic void calc(output longint pk, output longint pre,
                                 output longint post);
        longint run = 0;
        longint m;
        pk = 0; pre = 0;
        for (int i = 0; i < WIN; i++) begin
            m = (win[i] < 0) ? -longint'(win[i]) : longint'(win[i]);
            run += m;
            if (m > pk) begin
                pk  = m;
                pre = run;
            end
        end
        post = run - pre;
    endfunction

    // Send win[] as one window; called and returns at a negative edge.
    task automatic run_window(input int max_gap, input int extra_start);
        longint pk, pre, post;
        for (int i = 0; i < WIN; i++) begin
            int gap = (max_gap > 0) ? int'($urandom_range(max_gap, 0)) : 0;
            for (int g = 0; g < gap; g++) begin
                in_valid = 1'b0;
                in_start = 1'b0;
                in_last  = 1'b0;
                @(negedge clk);
            end
            in_valid  = 1'b1;
            in_start  = (i == 0) || (i == extra_start);
            in_last   = (i == WIN - 1);
            in_sample = win[i];
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_start = 1'b0;
        in_last  = 1'b0;
        chk("R7 ready low after final sample", longint'(in_ready), 0);
        chk("R6 no strobe one cycle after", longint'(out_valid), 0);
        @(negedge clk);
        calc(pk, pre, post);
        chk("R6 strobe two cycles after", longint'(out_valid), 1);
        chk("R7 ready back", longint'(in_ready), 1);
        chk("R5 peak magnitude", longint'(out_peak), pk);
        chk("R4 pre-peak area", longint'(out_pre_area), pre);
        chk("R4 post-peak area", longint'(out_post_area), post);
        chk("R3 total area", longint'(out_pre_area) + longint'(out_post_area),
            pre + post);
        @(negedge clk);
        chk("R6 strobe one cycle only", longint'(out_valid), 0);
        chk("R6 result held", longint'(out_pre_area), pre);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R6 watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2016));
        rst_n = 1'b0;
        in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0; in_sample = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", longint'(out_valid), 0);
        chk("R1 in_ready", longint'(in_ready), 1);
        chk("R1 out_peak", longint'(out_peak), 0);
        chk("R1 out_pre_area", longint'(out_pre_area), 0);
        chk("R1 out_post_area", longint'(out_post_area), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: all-zero window
        foreach (win[i]) win[i] = '0;
        run_window(0, -1);

        // R10 / R3: every sample at the most negative code
        foreach (win[i]) win[i] = {1'b1, {(SW-1){1'b0}}};
        run_window(0, -1);
        chk("R10 full-scale total", longint'(out_pre_area) + longint'(out_post_area),
            longint'(WIN) * (longint'(1) << (SW - 1)));

        // R8: peak on last sample of segment 0, first of segment 1, last overall
        foreach (win[i]) win[i] = SW'(i % 5);
        win[7] = 12'sd900;
        run_window(0, -1);
        foreach (win[i]) win[i] = -SW'(i % 3);
        win[8] = -12'sd700;
        run_window(1, -1);
        foreach (win[i]) win[i] = SW'(2);
        win[WIN-1] = 12'sd300;
        run_window(0, -1);

        // R5: ties across segments and within a segment
        foreach (win[i]) win[i] = SW'(1);
        win[3] = 12'sd100; win[20] = -12'sd100;
        run_window(0, -1);
        chk("R5 cross-segment tie pre", longint'(out_pre_area), 103);
        foreach (win[i]) win[i] = '0;
        win[9] = -12'sd50; win[12] = 12'sd50;
        run_window(0, -1);
        chk("R5 in-segment tie pre", longint'(out_pre_area), 50);

        // R2: idle samples without start are discarded
        for (int j = 0; j < 5; j++) begin
            in_valid = 1'b1; in_start = 1'b0; in_last = 1'b0;
            in_sample = 12'sd2047;
            @(negedge clk);
            chk("R2 idle sample no strobe", longint'(out_valid), 0);
        end
        in_valid = 1'b0;
        @(negedge clk);
        foreach (win[i]) win[i] = SW'(i);
        run_window(0, -1);

        // R9: stray start inside an open window is data
        foreach (win[i]) win[i] = SW'(3);
        win[15] = 12'sd40;
        run_window(0, 10);

        // R11 with random stimulus: gaps, full range and narrow range
        for (int n = 0; n < 40; n++) begin
            foreach (win[i]) begin
                if (n % 2 == 0)
                    win[i] = SW'($urandom_range(4095, 0));
                else
                    win[i] = SW'(int'($urandom_range(6, 0)) - 3);
            end
            run_window(2, -1);
            repeat (int'($urandom_range(2, 0))) @(negedge clk);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule